// File: doc/BRIEF.md
# Network Time-Code Controller

This block keeps the network time for a packet router. A local tick-in strobe makes it send a time-code to the link ports. The code carries either the next value of its own time counter or a value taken from an external input, depending on a configuration input. When a link port delivers a time-code from the network, the block checks that code against its stored count.

A code whose count is one step ahead of the stored count is accepted. For an accepted code the block pulses tick-out, shows the received code on its output, and passes the code on to the other enabled ports. A code that is not in sequence only re-aligns the stored count. The block drives a request bit per port with one shared code value. Each port drops its request bit with an acknowledge. The serial coding of the time-code on the wire is handled elsewhere.

A time-code is 8 bits wide. Bits [5:0] hold the count, which wraps from 63 to 0. Bits [7:6] hold two flag bits that the block passes on unchanged.

Top module: `tcode_ctrl`

## Requirements
- R1: After a synchronous reset, tx_req is 0, tick_out is 0, tc_out is 0 and the stored count is 0, so the first internal tick sends count 1.
- R2: A tick_in accepted with ext_mode=0 sets the stored count to the stored count plus one. It sends {tc_in[7:6], new count} on tx_code and sets tx_req to port_en, both visible in the cycle after the strobe.
- R3: A tick_in accepted with ext_mode=1 sends tc_in unchanged on tx_code, sets tx_req to port_en and loads tc_in[5:0] into the stored count.
- R4: The count wraps from 63 to 0 on an internal tick; the flag bits are not affected by the wrap.
- R5: A tick_in while any tx_req bit is set is ignored: tx_code, tx_req and the stored count are unchanged.
- R6: A tx_ack bit clears the matching tx_req bit at the next edge and leaves the other bits as they were.
- R7: A received code whose count equals the stored count plus one (mod 64) is valid. One cycle after it arrives, tick_out is 1 for that code and tc_out shows the whole 8-bit code.
- R8: An invalid received code loads its count into the stored count, raises no tick_out and leaves tc_out unchanged.
- R9: A valid received code that arrives while no tx_req bit is set is sent again, with tx_req = port_en minus the arrival port's bit. An invalid code, or any code that arrives while a request is pending, starts no new request.
- R10: When several ports present rx_valid in the same cycle, only the lowest-numbered port's code is used; the others are dropped.
- R11: An accepted tick_in takes precedence over a received code in the same cycle. That received code is dropped: no tick_out, and it does not affect the count.
- R12: tick_out is a one-cycle pulse for each valid code; it returns to 0 in the next cycle unless another valid code arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Local tick strobe, one cycle |
| ext_mode | input | 1 | 1: send tc_in as given; 0: send the incremented counter |
| tc_in | input | 8 | External time-code value; bits [7:6] give the flags in internal mode |
| port_en | input | N | Enabled link ports |
| tx_ack | input | N | Per-port acknowledge of a transmit request |
| rx_valid | input | N | Per-port received-code strobe |
| rx_code | input | 8*N | Received codes, port i in bits [8i+7:8i] |
| tx_req | output | N | Per-port transmit request |
| tx_code | output | 8 | Code to transmit, shared by all ports |
| tick_out | output | 1 | Valid time-code received |
| tc_out | output | 8 | Last valid received time-code |

## Verification
Directed ticks in both source modes tell the incremented count apart from the external value. They also show that the flags come from tc_in and that the count wraps at 63. Received codes are sent both in sequence and out of sequence, which separates the tick-out path from the re-alignment path. Collisions are driven on purpose: a tick while requests are pending, a tick and a received code in the same cycle, and two ports receiving at once. These show precedence and the choice of port. A long random run with partial acknowledges and changing port enables is then compared cycle by cycle against a bench model of the rules.

// File: rtl/tcode_pkg.sv
package tcode_pkg;
  localparam int CNT_W  = 6;
  localparam int FLAG_W = 2;
  localparam int CODE_W = CNT_W + FLAG_W;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [CNT_W-1:0]  count;
  } tcode_t;
endpackage

// File: rtl/tcode_rx_pick.sv
module tcode_rx_pick
  import tcode_pkg::*;
#(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        rx_valid,
  input  logic [N*CODE_W-1:0] rx_code,
  output logic                any,
  output logic [IDX_W-1:0]    idx,
  output tcode_t              code
);
  always_comb begin
    any  = |rx_valid;
    idx  = '0;
    code = '0;
    // Scan downwards so the lowest-numbered port wins.
    for (int i = N - 1; i >= 0; i--) begin
      if (rx_valid[i]) begin
        idx  = IDX_W'(i);
        code = rx_code[i*CODE_W +: CODE_W];
      end
    end
  end
endmodule

// File: rtl/tcode_core.sv
module tcode_core
  import tcode_pkg::*;
#(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic             ext_mode,
  input  tcode_t           tc_in,
  input  logic [N-1:0]     port_en,
  input  logic             pending,
  input  logic             rx_any,
  input  logic [IDX_W-1:0] rx_idx,
  input  tcode_t           rx_code,
  output logic             issue,
  output logic [N-1:0]     issue_mask,
  output tcode_t           issue_code,
  output logic             tick_out,
  output tcode_t           tc_out,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] next_cnt;
  logic             tick_ok;
  logic             rx_take;
  logic             rx_ok;
  tcode_t           local_code;
  logic [N-1:0]     src_mask;

  always_comb begin
    next_cnt   = cnt_q + CNT_W'(1);
    tick_ok    = tick_in & ~pending;
    rx_take    = rx_any & ~tick_ok;
    rx_ok      = rx_take & (rx_code.count == next_cnt);
    local_code = ext_mode ? tc_in : '{flags: tc_in.flags, count: next_cnt};
    src_mask   = N'(1) << rx_idx;
    issue      = tick_ok | (rx_ok & ~pending);
    issue_mask = tick_ok ? port_en : (port_en & ~src_mask);
    issue_code = tick_ok ? local_code : rx_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      tick_out <= 1'b0;
      tc_out   <= '0;
    end else begin
      tick_out <= rx_ok;
      if (tick_ok) begin
        cnt_q <= local_code.count;
      end else if (rx_take) begin
        cnt_q <= rx_code.count;
      end
      if (rx_ok) begin
        tc_out <= rx_code;
      end
    end
  end
endmodule

// File: rtl/tcode_tx_fanout.sv
module tcode_tx_fanout
  import tcode_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue,
  input  logic [N-1:0] issue_mask,
  input  tcode_t       issue_code,
  input  logic [N-1:0] tx_ack,
  output logic [N-1:0] tx_req,
  output tcode_t       tx_code,
  output logic         pending
);
  for (genvar g = 0; g < N; g++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        tx_req[g] <= 1'b0;
      end else if (issue) begin
        tx_req[g] <= issue_mask[g];
      end else if (tx_ack[g]) begin
        tx_req[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_code <= '0;
    end else if (issue) begin
      tx_code <= issue_code;
    end
  end

  assign pending = |tx_req;
endmodule

// File: rtl/tcode_ctrl.sv
module tcode_ctrl
  import tcode_pkg::*;
#(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_in,
  input  logic                ext_mode,
  input  logic [CODE_W-1:0]   tc_in,
  input  logic [N-1:0]        port_en,
  input  logic [N-1:0]        tx_ack,
  input  logic [N-1:0]        rx_valid,
  input  logic [N*CODE_W-1:0] rx_code,
  output logic [N-1:0]        tx_req,
  output logic [CODE_W-1:0]   tx_code,
  output logic                tick_out,
  output logic [CODE_W-1:0]   tc_out
);
  logic             rx_any;
  logic [IDX_W-1:0] rx_idx;
  tcode_t           rx_sel;
  logic             pending;
  logic             issue;
  logic [N-1:0]     issue_mask;
  tcode_t           issue_code;
  tcode_t           tx_code_s;
  tcode_t           tc_out_s;
  logic [CNT_W-1:0] cnt_w;

  tcode_rx_pick #(.N(N)) u_pick (
    .rx_valid (rx_valid),
    .rx_code  (rx_code),
    .any      (rx_any),
    .idx      (rx_idx),
    .code     (rx_sel)
  );

  tcode_core #(.N(N)) u_core (
    .clk        (clk),
    .rst        (rst),
    .tick_in    (tick_in),
    .ext_mode   (ext_mode),
    .tc_in      (tc_in),
    .port_en    (port_en),
    .pending    (pending),
    .rx_any     (rx_any),
    .rx_idx     (rx_idx),
    .rx_code    (rx_sel),
    .issue      (issue),
    .issue_mask (issue_mask),
    .issue_code (issue_code),
    .tick_out   (tick_out),
    .tc_out     (tc_out_s),
    .cnt_q      (cnt_w)
  );

  tcode_tx_fanout #(.N(N)) u_fan (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .issue_mask (issue_mask),
    .issue_code (issue_code),
    .tx_ack     (tx_ack),
    .tx_req     (tx_req),
    .tx_code    (tx_code_s),
    .pending    (pending)
  );

  assign tx_code = tx_code_s;
  assign tc_out  = tc_out_s;
endmodule

// File: rtl/tcode_ctrl_chk.sv
module tcode_ctrl_chk
  import tcode_pkg::*;
#(
  parameter int N = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_in,
  input logic              ext_mode,
  input logic [N-1:0]      rx_valid,
  input logic [N-1:0]      tx_ack,
  input logic [N-1:0]      tx_req,
  input logic [CODE_W-1:0] tx_code,
  input logic              tick_out,
  input logic [CODE_W-1:0] tc_out,
  input logic [CNT_W-1:0]  cnt
);
  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (rst)
    (|tx_req) |=> $stable(tx_code)); // R5

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (|(tx_req & tx_ack)) |=> ((tx_req & $past(tx_req & tx_ack)) == '0)); // R6

  AST_TICK_CAUSE: assert property (@(posedge clk) disable iff (rst)
    tick_out |-> $past(|rx_valid)); // R7

  AST_TCOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_out |-> $stable(tc_out)); // R8

  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (tx_req == '0) |=> ((tx_req == '0) || $past(tick_in || (|rx_valid)))); // R9

  AST_INT_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick_in && !ext_mode && tx_req == '0)
      |=> (tx_code[CNT_W-1:0] == CNT_W'($past(cnt) + CNT_W'(1)))); // R2
endmodule

bind tcode_ctrl tcode_ctrl_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_in  (tick_in),
  .ext_mode (ext_mode),
  .rx_valid (rx_valid),
  .tx_ack   (tx_ack),
  .tx_req   (tx_req),
  .tx_code  (tx_code),
  .tick_out (tick_out),
  .tc_out   (tc_out),
  .cnt      (cnt_w)
);

// File: tb/tcode_ctrl_test.sv
module tcode_ctrl_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_in = 1'b0;
  logic         ext_mode = 1'b0;
  logic [7:0]   tc_in = '0;
  logic [N-1:0] port_en = '0;
  logic [N-1:0] tx_ack = '0;
  logic [N-1:0] rx_valid = '0;
  logic [31:0]  rx_code = '0;
  logic [N-1:0] tx_req;
  logic [7:0]   tx_code;
  logic         tick_out;
  logic [7:0]   tc_out;

  int checks = 0;
  int failures = 0;

  logic [5:0]   m_cnt = '0;
  logic [N-1:0] m_req = '0;
  logic [7:0]   m_code = '0;
  logic         m_tick = 1'b0;
  logic [7:0]   m_tcout = '0;

  always #2 clk = ~clk;

  tcode_ctrl #(.N(N)) uut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .ext_mode(ext_mode),
    .tc_in(tc_in), .port_en(port_en), .tx_ack(tx_ack),
    .rx_valid(rx_valid), .rx_code(rx_code), .tx_req(tx_req),
    .tx_code(tx_code), .tick_out(tick_out), .tc_out(tc_out)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [5:0] inc6(input logic [5:0] v);
    return v + 6'd1;
  endfunction

  task automatic model(input logic tk, input logic ex, input logic [7:0] ti,
                       input logic [N-1:0] rv, input logic [31:0] rc,
                       input logic [N-1:0] ak, input logic [N-1:0] en);
    logic pend;
    logic [7:0] c;
    int p;
    pend = |m_req;
    m_tick = 1'b0;
    p = -1;
    for (int i = N - 1; i >= 0; i--) if (rv[i]) p = i;
    if (tk && !pend) begin
      c = ex ? ti : {ti[7:6], inc6(m_cnt)};
      m_cnt = c[5:0];
      m_req = en;
      m_code = c;
    end else if (p >= 0) begin
      c = rc[8*p +: 8];
      if (c[5:0] == inc6(m_cnt)) begin
        m_tick = 1'b1;
        m_tcout = c;
        if (!pend) begin
          m_req = en & ~(N'(1) << p);
          m_code = c;
        end else begin
          m_req = m_req & ~ak;
        end
      end else begin
        m_req = m_req & ~ak;
      end
      m_cnt = c[5:0];
    end else begin
      m_req = m_req & ~ak;
    end
  endtask

  task automatic step(input logic tk, input logic ex, input logic [7:0] ti,
                      input logic [N-1:0] rv, input logic [31:0] rc,
                      input logic [N-1:0] ak, input logic [N-1:0] en,
                      input string tag);
    tick_in = tk; ext_mode = ex; tc_in = ti; rx_valid = rv;
    rx_code = rc; tx_ack = ak; port_en = en;
    model(tk, ex, ti, rv, rc, ak, en);
    @(posedge clk);
    @(negedge clk);
    tick_in = 1'b0; rx_valid = '0; tx_ack = '0;
    chk({tag, " tx_req"}, 32'(tx_req), 32'(m_req));
    chk({tag, " tx_code"}, 32'(tx_code), 32'(m_code));
    chk({tag, " tick_out"}, 32'(tick_out), 32'(m_tick));
    chk({tag, " tc_out"}, 32'(tc_out), 32'(m_tcout));
  endtask

  task automatic idle(input string tag);
    step(0, 0, 8'h00, '0, '0, '0, 4'hF, tag);
  endtask

  task automatic ack_all(input string tag);
    step(0, 0, 8'h00, '0, '0, 4'hF, 4'hF, tag);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd13579;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset tx_req", 32'(tx_req), 0);
    chk("R1 reset tick_out", 32'(tick_out), 0);
    chk("R1 reset tc_out", 32'(tc_out), 0);

    // R2 internal tick after reset sends count 1 with flags from tc_in
    step(1, 0, 8'hC0, '0, '0, '0, 4'hF, "R2 internal tick");
    chk("R1 R2 first code", 32'(tx_code), 32'h0C1);
    chk("R2 request fanout", 32'(tx_req), 32'hF);

    // R5 tick while pending ignored
    step(1, 1, 8'h3F, '0, '0, '0, 4'hF, "R5 pending tick");
    chk("R5 code kept", 32'(tx_code), 32'h0C1);

    // R6 partial acknowledge
    step(0, 0, 8'h00, '0, '0, 4'h3, 4'hF, "R6 partial ack");
    chk("R6 remaining bits", 32'(tx_req), 32'hC);
    ack_all("R6 rest ack");
    chk("R6 all cleared", 32'(tx_req), 0);

    // R3 external value
    step(1, 1, 8'h7E, '0, '0, '0, 4'hF, "R3 external tick");
    chk("R3 external code", 32'(tx_code), 32'h07E);
    ack_all("R3 ack");

    // R4 wrap
    step(1, 0, 8'h00, '0, '0, '0, 4'hF, "R4 step to 63");
    chk("R4 count 63", 32'(tx_code), 32'h03F);
    ack_all("R4 ack");
    step(1, 0, 8'h40, '0, '0, '0, 4'hF, "R4 wrap");
    chk("R4 wrap to 0", 32'(tx_code), 32'h040);
    ack_all("R4 ack2");

    // R7 R9 valid receive on port 2
    step(0, 0, 8'h00, 4'b0100, 32'h0081_0000, '0, 4'hF, "R7 valid rx");
    chk("R7 tick_out", 32'(tick_out), 1);
    chk("R7 tc_out", 32'(tc_out), 32'h081);
    chk("R9 rebroadcast mask", 32'(tx_req), 32'hB);
    chk("R9 rebroadcast code", 32'(tx_code), 32'h081);
    step(0, 0, 8'h00, '0, '0, 4'hF, 4'hF, "R12 idle");
    chk("R12 tick_out drops", 32'(tick_out), 0);

    // R8 invalid receive realigns count
    step(0, 0, 8'h00, 4'b0010, 32'h0000_1500, '0, 4'hF, "R8 invalid rx");
    chk("R8 no tick", 32'(tick_out), 0);
    chk("R8 tc_out kept", 32'(tc_out), 32'h081);
    chk("R9 no request on invalid", 32'(tx_req), 0);
    step(1, 0, 8'h00, '0, '0, '0, 4'hF, "R8 realigned tick");
    chk("R8 count realigned", 32'(tx_code), 32'h016);
    ack_all("R8 ack");

    // R10 two ports, lowest wins
    step(0, 0, 8'h00, 4'b1010, 32'h2000_1700, '0, 4'hF, "R10 two rx");
    chk("R10 lowest port code", 32'(tc_out), 32'h017);
    chk("R10 source mask", 32'(tx_req), 32'hD);
    ack_all("R10 ack");

    // R11 tick beats receive in same cycle
    step(1, 0, 8'h00, 4'b0001, 32'h0000_0018, '0, 4'hF, "R11 collision");
    chk("R11 no tick_out", 32'(tick_out), 0);
    chk("R11 tick code", 32'(tx_code), 32'h018);
    // R9 valid rx while pending: tick_out but no new request
    step(0, 0, 8'h00, 4'b0001, 32'h0000_0019, '0, 4'hF, "R9 pending rx");
    chk("R9 pending tick_out", 32'(tick_out), 1);
    chk("R9 request held", 32'(tx_req), 32'hF);
    chk("R9 code held", 32'(tx_code), 32'h018);
    ack_all("R9 ack");

    // Random phase against the model
    for (int n = 0; n < 4000; n++) begin
      logic tk, ex;
      logic [7:0] ti;
      logic [N-1:0] rv, ak, en;
      logic [31:0] rc;
      tk = ($urandom % 5) == 0;
      ex = $urandom % 2;
      ti = 8'($urandom);
      en = (($urandom % 4) == 0) ? N'($urandom) : 4'hF;
      ak = N'($urandom);
      rv = '0;
      rc = '0;
      for (int i = 0; i < N; i++) begin
        rv[i] = ($urandom % 7) == 0;
        if (($urandom % 2) == 0) rc[8*i +: 8] = {2'($urandom), inc6(m_cnt)};
        else rc[8*i +: 8] = 8'($urandom);
      end
      step(tk, ex, ti, rv, rc, ak, en, "R2 R3 R5 R6 R7 R8 R9 R10 R11 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule